// File: doc/BRIEF.md
# Banked Per-Core Timer Block

This block holds one private countdown timer for each core, from one to four cores as set by a parameter, and places all of them behind one simple register bus. The address space is split into 32-byte windows. Window 0 is an alias: each access there reaches the timer of the core that issued it, as given by a core-ID input sampled with the request. Windows 1 to N reach the timers of cores 0 to N-1 at fixed addresses. A core can therefore program its own timer without knowing its own number, and a supervisor can still reach every timer directly.

Each timer counts down from a reload value, with an 8-bit prescaler and an optional automatic reload. It raises a sticky status bit when it expires, and that bit drives the core's own interrupt line. Read data and the error flag are combinational from the request in the same cycle. Writes take effect at the next clock edge.

Top module: `banked_core_timers`

## Requirements
- R1: After reset every register of every timer reads 0, and every interrupt output is 0.
- R2: In window 0 (address bits above bit 4 all zero), an access reaches the timer selected by `req_core`.
- R3: Window k+1 reaches the timer of core k. A value written through one path reads back the same through the other.
- R4: An access is invalid when it uses window 0 with `req_core` of N or more, or uses a window above N. An invalid access reads 0, raises `rsp_err` in that cycle, and changes no timer.
- R5: The register offset is address bits 4:0. 0x00 is the reload value, and writing it also loads the count. 0x04 is the live count. 0x08 is the control register: bit 0 enable, bit 1 auto-reload, bits 15:8 prescale, and all other bits read 0. 0x0C holds the status flag in bit 0. Every other offset reads 0 and ignores writes.
- R6: While a timer is enabled and its count is nonzero, the count drops by one every prescale+1 cycles. A write to that timer stalls the countdown for that cycle and restarts the prescaler if it loads the count.
- R7: When a count of 1 steps down, the status bit is set. The count then becomes the reload value if auto-reload is set, or else 0, and the timer stops.
- R8: Setting enable while it was clear restarts the prescaler. If the count is 0 and auto-reload is set in the same write, the count is loaded from the reload value.
- R9: Writing 0x0C with bit 0 set clears the status bit. `irq[i]` always equals the status bit of core i.
- R10: The timers are independent. An access to one core's timer never changes another's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window in bits above 4, offset in bits 4:0 |
| req_wdata | input | 32 | Write data |
| req_core | input | ID_W | ID of the requesting core, used by window 0 |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Invalid window or core ID this cycle |
| irq | output | NUM_CORES | Per-core interrupt, core 0 in bit 0 |

## Verification
The bench runs a cycle-accurate reference model with three cores, so the alias window can be given an out-of-range core ID. It aims at alias steering against direct windows. A design that decoded the alias from the wrong field would show one core's reload under another's window. It also aims at invalid accesses. A design that let them through would corrupt a timer, which later reads would expose. Prescaled countdown, expiry with and without auto-reload, enabling from a zero count, and clearing status during a countdown are all compared every cycle. An off-by-one in the prescaler or a lost reload shows up at once on the count reads and the `irq` lines.

// File: rtl/banked_core_timers.sv
module banked_core_timers #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int ID_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [ID_W-1:0]      req_core,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_CORES-1:0] irq
);
  localparam int WIN_W = ADDR_W - 5;

  logic [WIN_W-1:0] win;
  logic [4:0]       off;
  int               tgt;
  logic             ok;
  logic [NUM_CORES-1:0] hit;

  logic [31:0] load_q [NUM_CORES];
  logic [31:0] cnt_q  [NUM_CORES];
  logic [7:0]  psc_q  [NUM_CORES];
  logic [7:0]  pre_q  [NUM_CORES];
  logic [NUM_CORES-1:0] en_q, ar_q, st_q;

  assign win = req_addr[ADDR_W-1:5];
  assign off = req_addr[4:0];

  always_comb begin
    if (win == '0) tgt = int'(req_core);
    else           tgt = int'(win) - 1;
    ok = tgt < NUM_CORES;
  end

  assign rsp_err = req_valid && !ok;
  assign irq     = st_q;

  always_comb begin
    rsp_rdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (hit[i]) begin
        case (off)
          5'h00: rsp_rdata = load_q[i];
          5'h04: rsp_rdata = cnt_q[i];
          5'h08: rsp_rdata = {16'h0, psc_q[i], 6'h0, ar_q[i], en_q[i]};
          5'h0C: rsp_rdata = {31'h0, st_q[i]};
          default: rsp_rdata = '0;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic wr;
    assign hit[i] = req_valid && ok && (tgt == i);
    assign wr     = hit[i] && req_write;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q[i] <= '0;
        cnt_q[i]  <= '0;
        psc_q[i]  <= '0;
        pre_q[i]  <= '0;
        en_q[i]   <= 1'b0;
        ar_q[i]   <= 1'b0;
        st_q[i]   <= 1'b0;
      end else if (wr) begin
        case (off)
          5'h00: begin
            load_q[i] <= req_wdata;
            cnt_q[i]  <= req_wdata;
            pre_q[i]  <= '0;
          end
          5'h04: begin
            cnt_q[i] <= req_wdata;
            pre_q[i] <= '0;
          end
          5'h08: begin
            en_q[i]  <= req_wdata[0];
            ar_q[i]  <= req_wdata[1];
            psc_q[i] <= req_wdata[15:8];
            if (!en_q[i] && req_wdata[0]) begin
              pre_q[i] <= '0;
              if (cnt_q[i] == '0 && req_wdata[1]) cnt_q[i] <= load_q[i];
            end
          end
          5'h0C: if (req_wdata[0]) st_q[i] <= 1'b0;
          default: ;
        endcase
      end else if (en_q[i] && cnt_q[i] != '0) begin
        if (pre_q[i] == psc_q[i]) begin
          pre_q[i] <= '0;
          if (cnt_q[i] == 32'd1) begin
            st_q[i]  <= 1'b1;
            cnt_q[i] <= ar_q[i] ? load_q[i] : 32'd0;
          end else begin
            cnt_q[i] <= cnt_q[i] - 32'd1;
          end
        end else begin
          pre_q[i] <= pre_q[i] + 8'd1;
        end
      end
    end

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(hit[i] && req_write && req_addr[4:0] == 5'h0C && req_wdata[0]));
    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !hit[i]) |=> $stable(cnt_q[i]));
    // R7
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && cnt_q[i] == 32'd1 && pre_q[i] == psc_q[i] && !hit[i]) |=> irq[i]);
  end

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0 && hit == '0));
  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/test_banked_core_timers.sv
module test_banked_core_timers;
  localparam int PERIOD = 10;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic v = 0, w = 0;
  logic [7:0]  a = 0;
  logic [31:0] d = 0;
  logic [1:0]  c = 0;
  logic [31:0] rdata;
  logic        err;
  logic [N-1:0] irq;

  int checks = 0, fails = 0;
  string cur = "R1";

  logic [31:0] m_load [N];
  logic [31:0] m_cnt  [N];
  logic [7:0]  m_psc  [N], m_pre [N];
  logic        m_en [N], m_ar [N], m_st [N];

  banked_core_timers #(.NUM_CORES(N), .ADDR_W(8), .ID_W(2)) i_banked_core_timers (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(a),
    .req_wdata(d), .req_core(c), .rsp_rdata(rdata), .rsp_err(err), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  function automatic int target();
    return (a[7:5] == 0) ? int'(c) : int'(a[7:5]) - 1;
  endfunction

  task automatic step();
    int t;
    logic [31:0] er;
    logic [N-1:0] ei;
    t = target();
    er = 0;
    if (v && t < N) begin
      case (a[4:0])
        5'h00: er = m_load[t];
        5'h04: er = m_cnt[t];
        5'h08: er = {16'h0, m_psc[t], 6'h0, m_ar[t], m_en[t]};
        5'h0C: er = {31'h0, m_st[t]};
        default: er = 0;
      endcase
    end
    for (int i = 0; i < N; i++) ei[i] = m_st[i];
    chk("rdata", rdata, er);
    chk("err", {31'h0, err}, {31'h0, v && t >= N});
    chk("irq", {29'h0, irq}, {29'h0, ei});
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (v && w && t == i) begin
        if (a[4:0] == 5'h00) begin m_load[i] = d; m_cnt[i] = d; m_pre[i] = 0; end
        else if (a[4:0] == 5'h04) begin m_cnt[i] = d; m_pre[i] = 0; end
        else if (a[4:0] == 5'h08) begin
          if (!m_en[i] && d[0]) begin
            m_pre[i] = 0;
            if (m_cnt[i] == 0 && d[1]) m_cnt[i] = m_load[i];
          end
          m_en[i] = d[0]; m_ar[i] = d[1]; m_psc[i] = d[15:8];
        end else if (a[4:0] == 5'h0C && d[0]) m_st[i] = 0;
      end else if (m_en[i] && m_cnt[i] != 0) begin
        if (m_pre[i] == m_psc[i]) begin
          m_pre[i] = 0;
          if (m_cnt[i] == 1) begin m_st[i] = 1; m_cnt[i] = m_ar[i] ? m_load[i] : 0; end
          else m_cnt[i] = m_cnt[i] - 1;
        end else m_pre[i] = m_pre[i] + 1;
      end
    end
  endtask

  task automatic acc(logic vv, logic ww, logic [7:0] aa, logic [31:0] dd, logic [1:0] cc);
    @(negedge clk);
    v = vv; w = ww; a = aa; d = dd; c = cc;
    #1;
    step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) acc(0, 0, 0, 0, 0);
  endtask

  task automatic rd_all();
    for (int wi = 1; wi <= N; wi++)
      for (int o = 0; o < 16; o += 4) acc(1, 0, 8'((wi << 5) | o), 0, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog R6: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_load[i] = 0; m_cnt[i] = 0; m_psc[i] = 0; m_pre[i] = 0;
      m_en[i] = 0; m_ar[i] = 0; m_st[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1"; rd_all();
    cur = "R2";
    acc(1, 1, 8'h00, 32'hA1A1_0001, 2'd1);
    acc(1, 0, 8'h40, 0, 0);
    acc(1, 0, 8'h00, 0, 2'd1);
    acc(1, 0, 8'h04, 0, 2'd0);
    cur = "R3";
    acc(1, 1, 8'h20, 32'h0000_0C00, 0);
    acc(1, 1, 8'h60, 32'h0000_0C02, 0);
    acc(1, 0, 8'h00, 0, 2'd0);
    acc(1, 0, 8'h00, 0, 2'd2);
    acc(1, 0, 8'h04, 0, 2'd2);
    cur = "R4";
    acc(1, 1, 8'h00, 32'hDEAD_BEEF, 2'd3);
    acc(1, 1, 8'h80, 32'hDEAD_BEEF, 0);
    acc(1, 1, 8'hE8, 32'hFFFF_FFFF, 0);
    acc(1, 0, 8'hA0, 0, 0);
    rd_all();
    cur = "R5";
    acc(1, 1, 8'h30, 32'h1234_5678, 0);
    acc(1, 0, 8'h30, 0, 0);
    acc(1, 1, 8'h28, 32'hFFFF_F0FC, 0);
    acc(1, 0, 8'h28, 0, 0);
    acc(1, 1, 8'h26, 32'h0000_0005, 0);
    cur = "R10"; rd_all();
    cur = "R6";
    acc(1, 1, 8'h20, 32'd5, 0);
    acc(1, 1, 8'h28, 32'h0000_0201, 0);
    for (int k = 0; k < 8; k++) acc(1, 0, 8'h24, 0, 0);
    acc(1, 1, 8'h2C, 32'd1, 0);
    acc(1, 1, 8'h2C, 32'd1, 0);
    cur = "R7";
    for (int k = 0; k < 14; k++) acc(1, 0, 8'h24, 0, 0);
    cur = "R9";
    acc(1, 1, 8'h0C, 32'd1, 2'd0);
    acc(1, 1, 8'h2C, 32'd0, 0);
    acc(1, 0, 8'h2C, 0, 0);
    cur = "R8";
    acc(1, 1, 8'h40, 32'd3, 0);
    acc(1, 1, 8'h44, 32'd0, 0);
    acc(1, 1, 8'h48, 32'h0000_0003, 0);
    cur = "R7";
    for (int k = 0; k < 12; k++) acc(1, 0, 8'h04, 0, 2'd1);
    cur = "R9";
    acc(1, 1, 8'h4C, 32'd1, 0);
    idle(2);
    acc(1, 1, 8'h00, 32'd2, 2'd1);
    cur = "R6"; idle(10);
    cur = "R10"; rd_all();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule